// File: doc/BRIEF.md
# Legacy and Message Interrupt Merger with Message Queue

This block folds two kinds of interrupt source onto one interrupt line. Four level-sensitive legacy request lines are captured into sticky status bits that software clears by writing ones; a separate enable register decides which captured bits may drive the line. Inbound message-signalled interrupt writes are filtered by a programmable address window. A write that hits the window is queued, address and data together, in a first-in first-out buffer.

Software services the line from one handler. It reads the status and enable registers for the legacy lines and the queue summary bit. It then drains the queue: it reads the occupancy, the head data and the two halves of the head address, and reading the upper address half retires the entry. A full queue drops new messages and raises a sticky overflow flag. The interrupt line stays high while any enabled status bit is set, or while capture is on and the queue holds an entry.

Top module: `irq_merge_msiq`

## Requirements
- R1: A high level on legacy input i (i = 0..3) sets bit 5+i of the interrupt status register (offset 0xB1C) at the next clock edge. The bit stays set after the input drops.
- R2: Writing the status register clears each bit written as 1 and leaves bits written as 0. A legacy bit whose input is high in the clearing cycle stays set.
- R3: The enable register (offset 0xB0C) stores only bit 3 and bits 5..8. All other bits read as 0.
- R4: `irq_out` is high exactly when (status AND enable) is nonzero, or when capture is enabled and the queue is non-empty. It follows the registered state with no added delay.
- R5: A message write (`msi_valid`) is accepted only when capture enable (bit 0 of offset 0x14) is 1 and base <= address < base + size. The base low half is at 0x04, the base high half at 0x08 and the 32-bit size at 0x0C. Any other message write leaves the queue unchanged.
- R6: Accepted entries are read back in arrival order: data at 0x20, address bits 31:0 at 0x24 and address bits 63:32 at 0x28. A read of 0x28 removes the head entry. With the queue empty, these three offsets read 0 and nothing changes.
- R7: Offset 0x1C reports the queue occupancy, 0 to the depth (16 by default). Bit 0 of offset 0x18 is 1 exactly when the occupancy is nonzero.
- R8: An accepted message that arrives while the queue is full is discarded and sets the sticky overflow flag, bit 1 of offset 0x18. Writing 1 to that bit clears it.
- R9: Status bit 3 is set when a message enters the queue and is cleared by writing 1 to it.
- R10: `reg_rdata` takes the addressed value one cycle after `reg_rd` and holds it until the next read. Unmapped offsets read 0.
- R11: After reset, every register, the queue, the overflow flag and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| intx_in | input | 4 | Legacy level interrupt requests A..D |
| msi_valid | input | 1 | Inbound message write strobe |
| msi_addr | input | 64 | Inbound message write address |
| msi_data | input | 32 | Inbound message write data |
| irq_out | output | 1 | Merged interrupt output |

## Verification
The assertions assume a few things about the inputs. Register strobes and message strobes are single-cycle pulses that are sampled at the clock edge. At most one register access is presented per cycle, and the window base and size are not rewritten while a message write is in flight. The stimulus drives every input on the falling edge and pulses each strobe for one cycle. It reprograms the window only while `msi_valid` is low. The message addresses are chosen to fall just inside and just outside both window edges and into a different upper half, so the window compare is exercised at its boundaries.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  localparam int REG_AW  = 16;
  localparam int DW      = 32;
  localparam int MSI_AW  = 64;
  localparam int INTX_N  = 4;
  localparam int INTX_LSB = 5;
  localparam int MSUM_BIT = 3;

  // register map (byte offsets seen by the servicing software)
  localparam logic [REG_AW-1:0] OFS_INT_EN = 16'h0B0C;
  localparam logic [REG_AW-1:0] OFS_INT_ST = 16'h0B1C;
  localparam logic [REG_AW-1:0] OFS_WB_LO  = 16'h0004;
  localparam logic [REG_AW-1:0] OFS_WB_HI  = 16'h0008;
  localparam logic [REG_AW-1:0] OFS_WSIZE  = 16'h000C;
  localparam logic [REG_AW-1:0] OFS_CAPEN  = 16'h0014;
  localparam logic [REG_AW-1:0] OFS_QSTAT  = 16'h0018;
  localparam logic [REG_AW-1:0] OFS_QOCC   = 16'h001C;
  localparam logic [REG_AW-1:0] OFS_QDATA  = 16'h0020;
  localparam logic [REG_AW-1:0] OFS_QADRL  = 16'h0024;
  localparam logic [REG_AW-1:0] OFS_QADRH  = 16'h0028;

  typedef struct packed {
    logic [MSI_AW-1:0] addr;
    logic [DW-1:0]     data;
  } msi_ent_t;

  // true when addr lies in [base, base+size), computed without wrap
  function automatic logic in_window(input logic [MSI_AW-1:0] addr,
                                     input logic [MSI_AW-1:0] base,
                                     input logic [DW-1:0]     size);
    logic [MSI_AW:0] off;
    if (addr < base) return 1'b0;
    off = {1'b0, addr} - {1'b0, base};
    return off < {{(MSI_AW+1-DW){1'b0}}, size};
  endfunction

  // sticky bit update: clear-by-one, set wins
  function automatic logic sticky_next(input logic cur, input logic clr,
                                       input logic set);
    return (cur & ~clr) | set;
  endfunction

  // circular pointer advance for any depth
  function automatic int unsigned ptr_adv(input int unsigned p,
                                          input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/irqm_intx_status.sv
module irqm_intx_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_in,
  input  logic [N-1:0] clr_intx,
  input  logic         msi_set,
  input  logic         msi_clr,
  output logic [N-1:0] st_intx,
  output logic         st_msi
);
  import irqm_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_intx[i] <= 1'b0;
      else        st_intx[i] <= sticky_next(st_intx[i], clr_intx[i], lvl_in[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_msi <= 1'b0;
    else        st_msi <= sticky_next(st_msi, msi_clr, msi_set);
  end

  AST_INTX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_in != '0) |=> ((st_intx & $past(lvl_in)) == $past(lvl_in))); // R1

  AST_INTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_intx == '0) |=> ((st_intx & $past(st_intx)) == $past(st_intx))); // R2

  AST_MSUM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    msi_set |=> st_msi); // R9

endmodule

// File: rtl/irqm_msi_window.sv
module irqm_msi_window (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic [63:0] win_base,
  input  logic [31:0] win_size,
  input  logic        req_valid,
  input  logic [63:0] req_addr,
  output logic        accept
);
  import irqm_pkg::*;

  logic hit;
  assign hit    = in_window(req_addr, win_base, win_size);
  assign accept = req_valid & cap_en & hit;

  AST_ACCEPT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (cap_en && req_valid)); // R5

  AST_ZERO_SIZE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_size == '0) |-> !accept); // R5

endmodule

// File: rtl/irqm_msi_fifo.sv
module irqm_msi_fifo #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_req,
  input  irqm_pkg::msi_ent_t push_ent,
  input  logic               pop_req,
  output irqm_pkg::msi_ent_t head,
  output logic [CNT_W-1:0]   count,
  output logic               empty,
  output logic               full,
  output logic               dropped
);
  import irqm_pkg::*;

  msi_ent_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push_req & ~full;
  assign do_pop  = pop_req & ~empty;
  assign dropped = push_req & full;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= PTR_W'(ptr_adv(int'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= PTR_W'(ptr_adv(int'(rd_ptr), DEPTH));
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R7

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> (count <= $past(count))); // R8

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_req) |=> (count == '0)); // R6

endmodule

// File: rtl/irq_merge_msiq.sv
module irq_merge_msiq #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [3:0]  intx_in,
  input  logic        msi_valid,
  input  logic [63:0] msi_addr,
  input  logic [31:0] msi_data,
  output logic        irq_out
);
  import irqm_pkg::*;

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  // programmable state
  logic [31:0]       wb_lo, wb_hi, wsize;
  logic              cap_en;
  logic [INTX_N-1:0] en_intx;
  logic              en_msum;
  logic              q_ovf;
  logic [31:0]       rdata_q;

  // named internal events
  logic              wr_st, wr_en, wr_qst;
  logic              rd_pop;
  logic              msi_accept;
  logic              q_drop;
  logic              q_empty, q_full;
  logic [CNT_W-1:0]  q_count;
  msi_ent_t          q_head, q_in;
  logic [INTX_N-1:0] st_intx;
  logic              st_msi;
  logic              pend_masked;
  logic [31:0]       rd_mux;

  assign wr_st  = reg_wr && (reg_addr == OFS_INT_ST);
  assign wr_en  = reg_wr && (reg_addr == OFS_INT_EN);
  assign wr_qst = reg_wr && (reg_addr == OFS_QSTAT);
  assign rd_pop = reg_rd && (reg_addr == OFS_QADRH);
  assign q_in   = '{addr: msi_addr, data: msi_data};

  irqm_intx_status #(.N(INTX_N)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_in   (intx_in),
    .clr_intx (wr_st ? reg_wdata[INTX_LSB +: INTX_N] : '0),
    .msi_set  (msi_accept & ~q_full),
    .msi_clr  (wr_st & reg_wdata[MSUM_BIT]),
    .st_intx  (st_intx),
    .st_msi   (st_msi)
  );

  irqm_msi_window u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .win_base  ({wb_hi, wb_lo}),
    .win_size  (wsize),
    .req_valid (msi_valid),
    .req_addr  (msi_addr),
    .accept    (msi_accept)
  );

  irqm_msi_fifo #(.DEPTH(FIFO_DEPTH)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (msi_accept),
    .push_ent (q_in),
    .pop_req  (rd_pop),
    .head     (q_head),
    .count    (q_count),
    .empty    (q_empty),
    .full     (q_full),
    .dropped  (q_drop)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_lo   <= '0;
      wb_hi   <= '0;
      wsize   <= '0;
      cap_en  <= 1'b0;
      en_intx <= '0;
      en_msum <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_WB_LO: wb_lo  <= reg_wdata;
        OFS_WB_HI: wb_hi  <= reg_wdata;
        OFS_WSIZE: wsize  <= reg_wdata;
        OFS_CAPEN: cap_en <= reg_wdata[0];
        default: ;
      endcase
      if (wr_en) begin
        en_intx <= reg_wdata[INTX_LSB +: INTX_N];
        en_msum <= reg_wdata[MSUM_BIT];
      end
    end
  end

  // sticky overflow flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_ovf <= 1'b0;
    else        q_ovf <= sticky_next(q_ovf, wr_qst & reg_wdata[1], q_drop);
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_INT_ST: begin
        rd_mux[INTX_LSB +: INTX_N] = st_intx;
        rd_mux[MSUM_BIT]           = st_msi;
      end
      OFS_INT_EN: begin
        rd_mux[INTX_LSB +: INTX_N] = en_intx;
        rd_mux[MSUM_BIT]           = en_msum;
      end
      OFS_WB_LO: rd_mux = wb_lo;
      OFS_WB_HI: rd_mux = wb_hi;
      OFS_WSIZE: rd_mux = wsize;
      OFS_CAPEN: rd_mux[0] = cap_en;
      OFS_QSTAT: rd_mux[1:0] = {q_ovf, ~q_empty};
      OFS_QOCC:  rd_mux = 32'(q_count);
      OFS_QDATA: rd_mux = q_head.data;
      OFS_QADRL: rd_mux = q_head.addr[31:0];
      OFS_QADRH: rd_mux = q_head.addr[63:32];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end
  assign reg_rdata = rdata_q;

  // merged interrupt
  assign pend_masked = (|(st_intx & en_intx)) | (st_msi & en_msum);
  assign irq_out     = pend_masked | (~q_empty & cap_en);

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((st_intx != '0) || st_msi || (q_count != '0))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ovf && !wr_qst) |=> q_ovf); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R10

  AST_NONEMPTY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_accept && !q_full) |=> (q_count != '0)); // R7

endmodule

// File: tb/sim_irq_merge_msiq.sv
`timescale 1ns/1ps
module sim_irq_merge_msiq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  intx_in = '0;
  logic        msi_valid = 1'b0;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_merge_msiq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .intx_in(intx_in), .msi_valid(msi_valid), .msi_addr(msi_addr),
    .msi_data(msi_data), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_intx(input logic [3:0] v);
    intx_in = v;
    @(negedge clk);
    intx_in = '0;
  endtask

  task automatic send_msi(input logic [63:0] a, input logic [31:0] d);
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  // bench's own view of the window: offset from base must be below size
  function automatic bit hits(input logic [63:0] a, input logic [63:0] b,
                              input logic [31:0] s);
    logic [64:0] lim;
    lim = {1'b0, b} + {33'd0, s};
    return ({1'b0, a} >= {1'b0, b}) && ({1'b0, a} < lim);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [63:0] base;
    logic [31:0] wsz;
    int          exp_occ;
    logic [63:0] probe [6];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 irq", {31'd0, irq_out}, 32'd0);
    rd(16'h0B1C, v); check("R11 status", v, 0);
    rd(16'h0B0C, v); check("R11 enable", v, 0);
    rd(16'h001C, v); check("R11 occupancy", v, 0);
    rd(16'h0018, v); check("R11 qstat", v, 0);
    rd(16'h0014, v); check("R11 capen", v, 0);

    // R3 writable enable bits
    wr(16'h0B0C, 32'hFFFF_FFFF);
    rd(16'h0B0C, v); check("R3 enable mask", v, 32'h0000_01E8);
    wr(16'h0B0C, 32'h0);
    rd(16'h0B0C, v); check("R3 enable zero", v, 0);

    // R1 / R2 per line capture and clear
    for (int i = 0; i < 4; i++) begin
      pulse_intx(4'(1 << i));
      repeat (2) @(negedge clk);
      rd(16'h0B1C, v); check("R1 latch", v, 32'(1) << (5 + i));
      check("R4 masked quiet", {31'd0, irq_out}, 0);
      wr(16'h0B1C, 32'h0000_0010 | (32'(1) << (5 + ((i + 1) % 4))));
      rd(16'h0B1C, v); check("R2 clear other keeps", v, 32'(1) << (5 + i));
      wr(16'h0B1C, 32'(1) << (5 + i));
      rd(16'h0B1C, v); check("R2 clear", v, 0);
    end

    // R2 level held during clear
    intx_in = 4'b0100;
    @(negedge clk);
    wr(16'h0B1C, 32'h0000_01E0);
    rd(16'h0B1C, v); check("R2 held set wins", v, 32'h0000_0080);
    intx_in = '0;
    @(negedge clk);
    wr(16'h0B1C, 32'h0000_01E0);
    rd(16'h0B1C, v); check("R2 released clears", v, 0);

    // R4 sweep: status pattern x enable pattern
    for (int s = 0; s < 16; s++) begin
      pulse_intx(4'(s));
      for (int e = 0; e < 16; e++) begin
        wr(16'h0B0C, 32'(e) << 5);
        check("R4 sweep", {31'd0, irq_out}, {31'd0, ((s & e) != 0)});
      end
      wr(16'h0B1C, 32'h0000_01E0);
    end
    wr(16'h0B0C, 32'h0);

    // window programming
    base = 64'h0000_0001_0000_1000;
    wsz  = 32'h0000_1000;
    wr(16'h0004, base[31:0]);
    wr(16'h0008, base[63:32]);
    wr(16'h000C, wsz);
    rd(16'h0008, v); check("R5 base hi readback", v, 32'h1);

    // R5 capture disabled ignores in-window writes
    send_msi(base, 32'hDEAD);
    rd(16'h001C, v); check("R5 disabled ignored", v, 0);
    check("R4 disabled quiet", {31'd0, irq_out}, 0);

    wr(16'h0014, 32'h1);
    probe[0] = base - 64'd4;
    probe[1] = base;
    probe[2] = base + 64'(wsz) - 64'd4;
    probe[3] = base + 64'(wsz);
    probe[4] = {32'h0000_0002, base[31:0]};
    probe[5] = {32'h0, base[31:0]};
    exp_occ = 0;
    for (int k = 0; k < 6; k++) begin
      send_msi(probe[k], 32'hA0 + 32'(k));
      if (hits(probe[k], base, wsz)) exp_occ++;
    end
    rd(16'h001C, v); check("R5 window edges occupancy", v, 32'(exp_occ));
    rd(16'h0018, v); check("R7 nonempty bit", v, 32'h1);
    rd(16'h0B1C, v); check("R9 summary set", v, 32'h8);
    check("R4 queue drives irq", {31'd0, irq_out}, 1);

    // R6 drain in order
    for (int k = 0; k < 6; k++) begin
      if (hits(probe[k], base, wsz)) begin
        rd(16'h0020, v); check("R6 data", v, 32'hA0 + 32'(k));
        rd(16'h0024, v); check("R6 addr lo", v, probe[k][31:0]);
        rd(16'h0028, v); check("R6 addr hi", v, probe[k][63:32]);
      end
    end
    rd(16'h0018, v); check("R7 empty bit", v, 0);
    rd(16'h0020, v); check("R6 empty data", v, 0);
    rd(16'h0028, v); check("R6 empty addr hi", v, 0);
    rd(16'h001C, v); check("R6 empty pop no change", v, 0);
    check("R4 drained quiet", {31'd0, irq_out}, 0);

    // R9 clear and enable of summary bit
    wr(16'h0B0C, 32'h8);
    check("R4 summary enabled", {31'd0, irq_out}, 1);
    wr(16'h0B1C, 32'h8);
    rd(16'h0B1C, v); check("R9 summary cleared", v, 0);
    check("R4 summary cleared quiet", {31'd0, irq_out}, 0);
    wr(16'h0B0C, 32'h0);

    // R7 / R8 fill to depth, then overflow
    for (int k = 0; k < 16; k++) send_msi(base + 64'(4 * k), 32'h100 + 32'(k));
    rd(16'h001C, v); check("R7 full occupancy", v, 32'd16);
    rd(16'h0018, v); check("R8 no overflow yet", v, 32'h1);
    send_msi(base + 64'h40, 32'h999);
    rd(16'h001C, v); check("R8 drop keeps occupancy", v, 32'd16);
    rd(16'h0018, v); check("R8 overflow set", v, 32'h3);
    for (int k = 0; k < 16; k++) begin
      rd(16'h0020, v); check("R8 surviving data", v, 32'h100 + 32'(k));
      rd(16'h0028, v);
    end
    rd(16'h001C, v); check("R8 dropped entry absent", v, 0);
    rd(16'h0018, v); check("R8 overflow sticky", v, 32'h2);
    wr(16'h0018, 32'h2);
    rd(16'h0018, v); check("R8 overflow cleared", v, 0);

    // R10 unmapped read and hold
    rd(16'h0200, v); check("R10 unmapped", v, 0);
    rd(16'h000C, v); check("R10 size read", v, wsz);
    repeat (3) @(negedge clk);
    check("R10 hold", reg_rdata, wsz);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule